// File: doc/BRIEF.md
# Block Write-Protection Walker

This block holds a protection state for every erase block of a flash array. Each block is in one of three states: open (writable), locked, or tight. Tight is a permanent lock that no later command can undo. Software first loads a first-block and a last-block pointer. It then issues one of four walk commands: open a range, open everything, lock a range, or tighten a range. The controller visits one block per clock and updates each block it visits. It keeps the most recently written state in a status word.

When the walk ends, the block pulses `done` and raises a sticky interrupt-pending flag. A walk that runs past the array also raises a sticky error flag. Software clears both flags with `irq_ack`. No new command is taken while a walk is in progress or while the pending flag is set.

The program and erase logic use a separate combinational query port. It reports the state of any block and whether that block is protected.

Top module: `lockp_ctrl`

## Requirements
- R1: Block states are one-hot: tight = 3'b001, locked = 3'b010, open = 3'b100. `qry_state` returns the state of block `qry_blk`. `qry_protected` is 1 unless that block is open. For an index at or above NUM_BLOCKS, the query returns state 3'b000 and protected = 1.
- R2: Reset has the following effects:
  - Every block becomes locked.
  - `wp_status` becomes 3'b010.
  - `busy`, `done`, `cmd_err` and `int_pend` become 0.
  - Both pointers become 0.
- R3: A write with `start_we` loads `addr_wdata` into both the first and the last pointer. A write with `end_we` loads only the last pointer. Either write takes effect at the next clock edge.
- R4: A command is accepted when `cmd_valid` is high, `busy` is low and `int_pend` is low. In any other cycle `cmd_valid` is ignored, and no state, flag or status changes as a result.
- R5: Code 8'h23 opens blocks from the first pointer up to the last pointer. The walk halts, with no change, at the first tight block it meets.
- R6: Code 8'h2A locks blocks from the first pointer up to the last pointer. The walk halts, with no change, at the first tight block it meets.
- R7: Code 8'h27 opens blocks from index 0 up to NUM_BLOCKS-1. The walk halts at the first tight block.
- R8: Code 8'h2C makes every block in the range tight, except blocks that are open, which it passes over. A tight block never leaves the tight state.
- R9: A range walk that reaches an index at or above NUM_BLOCKS stops there and sets `cmd_err`. Any code not listed in R5 to R8 also sets `cmd_err`, and its walk takes one cycle with no state change.
- R10: Each block the walk writes also copies its new state into `wp_status`.
- R11: Timing of a walk:
  - The walk visits one block per clock. `busy` is high from the cycle after acceptance.
  - A walk that stops on its Nth visited block ends N cycles after acceptance. A range whose first pointer is greater than its last pointer ends after 1 cycle.
  - At the end, `busy` falls and `done` is high for exactly one cycle.
- R12: `int_pend` rises together with `done`. `irq_ack` clears both `int_pend` and `cmd_err`. If the two coincide, the end of a walk takes priority over `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; all blocks become locked |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| start_we | input | 1 | Write the first pointer (also copies into the last pointer) |
| end_we | input | 1 | Write the last pointer |
| addr_wdata | input | ADDR_W | Pointer write data |
| irq_ack | input | 1 | Clear the pending and error flags |
| qry_blk | input | ADDR_W | Block index for the protection query |
| start_addr | output | ADDR_W | First pointer |
| end_addr | output | ADDR_W | Last pointer |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| cmd_err | output | 1 | Sticky error flag |
| int_pend | output | 1 | Sticky completion flag |
| wp_status | output | 3 | State most recently written by a walk |
| qry_state | output | 3 | State of the queried block |
| qry_protected | output | 1 | Queried block is not open |

## Verification
Pointer writes are due one cycle after the strobe. A walk that stops on its Nth block shows `busy` one cycle after acceptance, and `done`, `int_pend` and the sticky error N cycles after acceptance. The bench's reference model computes the outcome of each walk and its cycle count N when it accepts the command. It then counts down that many clock edges before it expects the end. Flags and pointers are compared after every edge. Per-block state, the status word and the query port change while a walk is still in progress, so the bench compares them only while its model is idle. The query index steps through all blocks, including those above the array, so every block is compared over time.

// File: rtl/lockp_pkg.sv
package lockp_pkg;

  typedef enum logic [2:0] {
    BS_TIGHT  = 3'b001,
    BS_LOCKED = 3'b010,
    BS_OPEN   = 3'b100
  } blk_state_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_OPEN,
    OP_LOCK,
    OP_TIGHT,
    OP_BAD
  } walk_op_t;

  localparam logic [7:0] CMD_OPEN_RANGE  = 8'h23;
  localparam logic [7:0] CMD_OPEN_ALL    = 8'h27;
  localparam logic [7:0] CMD_LOCK_RANGE  = 8'h2A;
  localparam logic [7:0] CMD_TIGHT_RANGE = 8'h2C;

  typedef struct packed {
    logic       wr;
    logic       halt;
    blk_state_t nxt;
  } step_t;

  function automatic walk_op_t decode_cmd(input logic [7:0] code);
    case (code)
      CMD_OPEN_RANGE, CMD_OPEN_ALL: return OP_OPEN;
      CMD_LOCK_RANGE:               return OP_LOCK;
      CMD_TIGHT_RANGE:              return OP_TIGHT;
      default:                      return OP_BAD;
    endcase
  endfunction

  // Decide what one visited block does under a given walk.
  function automatic step_t block_step(input walk_op_t op, input blk_state_t cur);
    step_t s;
    s.wr   = 1'b0;
    s.halt = 1'b0;
    s.nxt  = cur;
    case (op)
      OP_OPEN, OP_LOCK: begin
        if (cur == BS_TIGHT) s.halt = 1'b1;
        else begin
          s.wr  = 1'b1;
          s.nxt = (op == OP_OPEN) ? BS_OPEN : BS_LOCKED;
        end
      end
      OP_TIGHT: begin
        if (cur != BS_OPEN) begin
          s.wr  = 1'b1;
          s.nxt = BS_TIGHT;
        end
      end
      default: s.halt = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lockp_addr_regs.sv
module lockp_addr_regs #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_we,
  input  logic              end_we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (start_we) begin
      start_q <= wdata;
      end_q   <= wdata;
    end else if (end_we) begin
      end_q   <= wdata;
    end
  end

  // R3: writing the first pointer also loads the last pointer
  a_r3_start_copies_end: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> (end_q == $past(wdata)) && (start_q == $past(wdata)));

endmodule

// File: rtl/lockp_state_array.sv
module lockp_state_array
  import lockp_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  blk_state_t        wr_state,
  input  logic [ADDR_W-1:0] walk_idx,
  output blk_state_t        walk_state,
  input  logic [ADDR_W-1:0] qry_idx,
  output blk_state_t        qry_state
);

  blk_state_t st_q [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   st_q[g] <= BS_LOCKED;
      else if (wr_en && (32'(wr_idx) == 32'(g)))    st_q[g] <= wr_state;
    end

    // R8: a tight block stays tight
    a_r8_tight_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == BS_TIGHT) |=> (st_q[g] == BS_TIGHT));
  end

  always_comb begin
    walk_state = blk_state_t'(3'b000);
    qry_state  = blk_state_t'(3'b000);
    if (32'(walk_idx) < NUM_BLOCKS) walk_state = st_q[walk_idx];
    if (32'(qry_idx)  < NUM_BLOCKS) qry_state  = st_q[qry_idx];
  end

  // R1: only one-hot states are ever stored
  a_r1_write_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(wr_state));

endmodule

// File: rtl/lockp_walker.sv
module lockp_walker
  import lockp_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [7:0]        code,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [ADDR_W-1:0] end_ptr,
  input  blk_state_t        cur_state,
  output logic              busy,
  output logic [ADDR_W-1:0] idx,
  output logic              wr_en,
  output blk_state_t        wr_state,
  output logic              fin,
  output logic              err_evt
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_BLOCKS - 1);

  logic              busy_q;
  walk_op_t          op_q;
  logic [ADDR_W-1:0] idx_q, last_q;
  logic              past_end, oob;
  step_t             step;
  walk_op_t          op_in;

  assign op_in    = decode_cmd(code);
  assign past_end = idx_q > last_q;
  assign oob      = 32'(idx_q) >= NUM_BLOCKS;
  assign step     = block_step(op_q, cur_state);

  assign busy     = busy_q;
  assign idx      = idx_q;
  assign fin      = busy_q & (past_end | oob | step.halt | (idx_q == last_q));
  assign err_evt  = busy_q & ~past_end & (oob | (op_q == OP_BAD));
  assign wr_en    = busy_q & ~past_end & ~oob & step.wr;
  assign wr_state = step.nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      idx_q  <= '0;
      last_q <= '0;
    end else if (busy_q) begin
      if (fin) busy_q <= 1'b0;
      else     idx_q  <= idx_q + 1'b1;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= op_in;
      if (code == CMD_OPEN_ALL) begin
        idx_q  <= '0;
        last_q <= LAST_IDX;
      end else if (op_in == OP_BAD) begin
        idx_q  <= '0;
        last_q <= '0;
      end else begin
        idx_q  <= start_ptr;
        last_q <= end_ptr;
      end
    end
  end

  // R11: walk starts the cycle after acceptance
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !busy_q) |=> busy_q);
  // R11: one block per clock
  a_r11_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> busy_q && (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/lockp_ctrl.sv
module lockp_ctrl
  import lockp_pkg::*;
#(
  parameter int   NUM_BLOCKS = 12,
  localparam int  ADDR_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              start_we,
  input  logic              end_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] qry_blk,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] end_addr,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              int_pend,
  output logic [2:0]        wp_status,
  output logic [2:0]        qry_state,
  output logic              qry_protected
);

  logic              accept;
  logic              walk_busy, walk_fin, walk_err, wr_en;
  logic [ADDR_W-1:0] walk_idx;
  blk_state_t        wr_state, walk_state, q_state;
  logic              done_q, err_q, int_q;
  logic [2:0]        wp_q;

  assign accept = cmd_valid & ~walk_busy & ~int_q;

  lockp_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
    .wdata(addr_wdata), .start_q(start_addr), .end_q(end_addr)
  );

  lockp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .code(cmd_code),
    .start_ptr(start_addr), .end_ptr(end_addr), .cur_state(walk_state),
    .busy(walk_busy), .idx(walk_idx), .wr_en(wr_en), .wr_state(wr_state),
    .fin(walk_fin), .err_evt(walk_err)
  );

  lockp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(walk_idx),
    .wr_state(wr_state), .walk_idx(walk_idx), .walk_state(walk_state),
    .qry_idx(qry_blk), .qry_state(q_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      wp_q   <= BS_LOCKED;
    end else begin
      done_q <= walk_fin;
      if (wr_en) wp_q <= wr_state;
      if (walk_fin) begin
        int_q <= 1'b1;
        if (walk_err) err_q <= 1'b1;
      end else if (irq_ack) begin
        int_q <= 1'b0;
        err_q <= 1'b0;
      end
    end
  end

  assign busy          = walk_busy;
  assign done          = done_q;
  assign cmd_err       = err_q;
  assign int_pend      = int_q;
  assign wp_status     = wp_q;
  assign qry_state     = q_state;
  assign qry_protected = (q_state != BS_OPEN);

  // R12: completion always leaves the pending flag set
  a_r12_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int_pend);
  // R11: done is a single-cycle pulse that coincides with busy falling
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R4: no walk starts while the pending flag is set
  a_r4_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && !busy) |=> !busy);
  // R10: status tracks every block written
  a_r10_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wp_status == $past(wr_state));

endmodule

// File: tb/tb_lockp_ctrl.sv
module tb_lockp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, start_we = 1'b0, end_we = 1'b0, irq_ack = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [AW-1:0] addr_wdata = '0, qry_blk = '0;
  logic [AW-1:0] start_addr, end_addr;
  logic busy, done, cmd_err, int_pend, qry_protected;
  logic [2:0] wp_status, qry_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockp_ctrl #(.NUM_BLOCKS(NB)) dut (.*);

  int vectors = 0, fails = 0;
  // reference model
  int mst[NB], pst[NB];
  int mwp, pwp, ms, me, rem;
  bit mbusy, mdone, mint, merr, perr;

  task automatic model_reset();
    for (int b = 0; b < NB; b++) mst[b] = 2;
    mwp = 2; ms = 0; me = 0; rem = 0;
    mbusy = 0; mdone = 0; mint = 0; merr = 0;
  endtask

  task automatic model_accept(input int code);
    int lo, hi, cyc;
    for (int b = 0; b < NB; b++) pst[b] = mst[b];
    pwp = mwp; perr = 0; cyc = 0;
    if (code == 'h23 || code == 'h2A || code == 'h2C) begin lo = ms; hi = me; end
    else if (code == 'h27) begin lo = 0; hi = NB - 1; end
    else begin lo = 1; hi = 0; perr = 1; end
    for (int b = lo; b <= hi; b++) begin
      cyc++;
      if (b >= NB) begin perr = 1; break; end
      if (code == 'h2C) begin
        if (pst[b] != 4) begin pst[b] = 1; pwp = 1; end
      end else begin
        if (pst[b] == 1) break;
        pst[b] = (code == 'h2A) ? 2 : 4;
        pwp = pst[b];
      end
    end
    rem = (cyc == 0) ? 1 : cyc;
    mbusy = 1;
  endtask

  task automatic model_step();
    bit ob, oi;
    ob = mbusy; oi = mint; mdone = 0;
    if (irq_ack) begin mint = 0; merr = 0; end
    if (ob) begin
      rem--;
      if (rem == 0) begin
        mbusy = 0; mdone = 1; mint = 1;
        if (perr) merr = 1;
        for (int b = 0; b < NB; b++) mst[b] = pst[b];
        mwp = pwp;
      end
    end else if (cmd_valid && !oi) model_accept(int'(cmd_code));
    if (start_we) begin ms = int'(addr_wdata); me = int'(addr_wdata); end
    else if (end_we) me = int'(addr_wdata);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int q, es;
    vectors++;
    chk(busy == mbusy, "R11 busy", busy, mbusy);
    chk(done == mdone, "R11 done", done, mdone);
    chk(int_pend == mint, "R12 int_pend", int_pend, mint);
    chk(cmd_err == merr, "R9 cmd_err", cmd_err, merr);
    chk(int'(start_addr) == ms, "R3 start_addr", start_addr, ms);
    chk(int'(end_addr) == me, "R3 end_addr", end_addr, me);
    if (!mbusy) begin
      q = int'(qry_blk);
      es = (q < NB) ? mst[q] : 0;
      chk(int'(wp_status) == mwp, "R10 wp_status", wp_status, mwp);
      chk(int'(qry_state) == es, "R1 qry_state", qry_state, es);
      chk(qry_protected == (es != 4), "R1 qry_protected", qry_protected, es != 4);
    end
    qry_blk = qry_blk + 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_valid = 0; start_we = 0; end_we = 0; irq_ack = 0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1;
    compare();
  endtask

  task automatic set_start(input int v);
    start_we = 1; addr_wdata = AW'(v); step(); start_we = 0;
  endtask

  task automatic set_end(input int v);
    end_we = 1; addr_wdata = AW'(v); step(); end_we = 0;
  endtask

  task automatic run(input int code, input bit ack);
    cmd_valid = 1; cmd_code = 8'(code); step(); cmd_valid = 0;
    while (mbusy) step();
    step();
    if (ack) begin irq_ack = 1; step(); irq_ack = 0; end
  endtask

  task automatic sweep();
    for (int i = 0; i < 16; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    sweep();                                // R2 reset state, R1 query over all blocks
    set_start(2); set_end(5); run('h23, 1); // R5 range open
    set_start(3); run('h2A, 1);             // R3 copy to end, R6 single lock
    sweep();
    set_start(0); set_end(4); run('h2C, 1); // R8 tight skips open blocks
    set_start(0); set_end(7); run('h23, 1); // R5 halts at tight block 0
    set_start(3); set_end(9); run('h2A, 1); // R6 halts at tight block 3
    run('h27, 1);                           // R7 halts immediately
    set_start(10); set_end(14); run('h23, 1); // R9 runs past the array
    set_start(6); set_end(2); run('h2A, 1); // R11 empty range takes one cycle
    run('h55, 1);                           // R9 unknown code
    run('h2C, 0);                           // R12 pending without ack
    set_start(7); run('h2A, 0);             // R4 ignored while pending
    irq_ack = 1; step(); irq_ack = 0;       // R12 ack clears
    sweep();
    do_reset();                             // R2 back to all locked
    cmd_valid = 1; cmd_code = 8'h27; step();
    cmd_code = 8'h2A; step(); step(); cmd_valid = 0; // R4 ignored while busy
    while (mbusy) step();
    step(); irq_ack = 1; step(); irq_ack = 0;        // R7 full walk
    set_start(8); run('h2A, 1);
    set_start(8); set_end(9); run('h2C, 1); // R8
    run('h27, 1);                           // R7 stops at block 8
    set_start(0); set_end(11); run('h2C, 1); // R10 status after tightening
    run('h23, 1);                           // R8 tight is permanent
    sweep();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule